// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Cache

This block sits between a processor load/store port and a slower word memory. It keeps 1024 one-word lines organised as 256 sets of four ways. A lookup selects one set with the index bits of the address and compares the four stored tags at the same time. A valid match returns its word in the same cycle.

A read that misses waits for every queued write to reach memory. It then fetches the word and places it in a free way of the set, or in a way chosen by a free-running LFSR when the set is full. The lookup that follows then hits. Writes never allocate a line. Each write updates the cached word when it hits and is always queued in a four-entry buffer, so the processor stalls on a write only when that buffer is full.

The processor holds `cpu_req` and its address and data steady until `cpu_ready` is high. The memory side holds `mem_req` and its fields steady until `mem_ack` is high for one cycle. A read returns its data on `mem_rdata` in the cycle that `mem_ack` is high.

Top module: `sa4_wt_cache`

## Requirements
- R1: Address bits [1:0] select a byte within the word and do not affect lookup. Bits [9:2] pick one of 256 sets, and bits [31:10] form the 22-bit tag. Two addresses that differ only in bits [1:0] hit the same line.
- R2: A read whose tag matches a valid way in its set gets `cpu_ready` high in the same cycle. `cpu_rdata` carries that way's word, `cpu_hit` is high, and `cpu_hit_way` has bit w set for the matching way w.
- R3: `cpu_hit_way` never has more than one bit set.
- R4: A read miss keeps `cpu_ready` low. No memory read (`mem_req` high with `mem_we` low) is issued while any write is still queued. The fetch carries the request address in `mem_addr`, and the lookup in the cycle after `mem_ack` hits with the memory's current word for that address.
- R5: A fill goes to the lowest-numbered invalid way of the set. Only when all four ways are valid is the way taken from the LFSR.
- R6: Every accepted write appears on the memory port once, with `mem_we` high, word address and data unchanged, and in the order the writes were accepted.
- R7: A write that hits replaces the cached word, so a read of the same word in the next cycle returns the new data from the cache.
- R8: A write that misses installs nothing, so a later read of that address misses.
- R9: The write buffer holds four writes. A write is accepted in the cycle it is presented when fewer than four are pending, and it stalls with `cpu_ready` low while four are pending.
- R10: After reset all ways are invalid, the write buffer is empty and `mem_req` is low.
- R11: Once `mem_req` is high it stays high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| cpu_hit | output | 1 | Lookup matched a valid way |
| cpu_hit_way | output | 4 | One-hot matching way |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address (bits [1:0] ignored by memory) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Transfer done, one-cycle pulse |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A wrong valid bit or tag shows up at once as a wrong `cpu_hit`, `cpu_ready` or `cpu_hit_way` on the next access to that set. A wrong data word shows up as a wrong `cpu_rdata` on the first read hit of it. A fetch issued before the buffer has drained returns an old memory word, and the first read after such a miss exposes it. A lost, duplicated or reordered buffer entry shows up on the memory port at that entry's acknowledge. A fill that skips a free way is visible in `cpu_hit_way` one cycle after the fetch acknowledge.

// File: rtl/sa4c_pkg.sv
package sa4c_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FETCH
  } fill_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/sa4c_lfsr.sv
module sa4c_lfsr #(
  parameter int              W     = 8,
  parameter int              OUT_W = 2,
  parameter logic [W-1:0]    TAPS  = 8'hB8,
  parameter logic [W-1:0]    SEED  = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= step(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];

  // the register must never fall into the all-zero lock-up state
  a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/sa4c_wbuf.sv
module sa4c_wbuf
  import sa4c_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_entry,
  input  logic      pop,
  output wb_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_entry;
  end

  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/sa4c_ways.sv
module sa4c_ways #(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_idx,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic [WAYS-1:0]          hit_vec,
  output logic [DATA_W-1:0]        hit_data,
  output logic [WAYS-1:0]          set_valid,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     fill_en,
  input  logic [WAYS-1:0]          fill_way,
  input  logic [DATA_W-1:0]        fill_data
);
  logic [DATA_W-1:0] way_word [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vbits;
    logic [TAG_W-1:0]  tags  [SETS];
    logic [DATA_W-1:0] words [SETS];
    logic              do_fill, do_upd;

    assign do_fill = fill_en && fill_way[w];
    assign do_upd  = wr_en && hit_vec[w];

    always_ff @(posedge clk) begin
      if (!rst_n)       vbits <= '0;
      else if (do_fill) vbits[lk_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (do_fill) begin
        tags[lk_idx]  <= lk_tag;
        words[lk_idx] <= fill_data;
      end else if (do_upd) begin
        words[lk_idx] <= wr_data;
      end
    end

    assign set_valid[w] = vbits[lk_idx];
    assign hit_vec[w]   = vbits[lk_idx] && (tags[lk_idx] == lk_tag);
    assign way_word[w]  = words[lk_idx];
  end

  // and-or multiplexer over the ways, steered by the match vector
  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_data = hit_data | (way_word[w] & {DATA_W{hit_vec[w]}});
    end
  end

  a_r3_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r8_fill_not_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !wr_en);
endmodule

// File: rtl/sa4_wt_cache.sv
module sa4_wt_cache
  import sa4c_pkg::*;
#(
  parameter int             SETS       = 256,
  parameter int             WAYS       = 4,
  parameter int             WB_DEPTH   = 4,
  parameter int             WORD_BYTES = 4,
  parameter int             LFSR_W     = 8,
  parameter logic [7:0]     LFSR_TAPS  = 8'hB8,
  parameter logic [7:0]     LFSR_SEED  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_hit,
  output logic [WAYS-1:0]   cpu_hit_way,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WIDX_W = $clog2(WAYS);

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WAYS-1:0] pick_victim(input logic [WAYS-1:0] valid,
                                                  input logic [WIDX_W-1:0] rnd);
    logic [WAYS-1:0] sel;
    logic            found;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) sel[rnd] = 1'b1;
    return sel;
  endfunction

  // named internal events
  fill_state_e       state_q, state_d;
  logic [WAYS-1:0]   hit_vec, set_valid, fill_way;
  logic [DATA_W-1:0] hit_data;
  logic [WIDX_W-1:0] rnd;
  logic              lookup_hit, rd_miss, wr_accept, fill_en;
  logic              wb_empty, wb_full, wb_pop;
  wb_entry_t         wb_head, wb_in;

  sa4c_lfsr #(
    .W(LFSR_W), .OUT_W(WIDX_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) i_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  sa4c_ways #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) i_ways (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(addr_index(cpu_addr)), .lk_tag(addr_tag(cpu_addr)),
    .hit_vec(hit_vec), .hit_data(hit_data), .set_valid(set_valid),
    .wr_en(wr_accept), .wr_data(cpu_wdata),
    .fill_en(fill_en), .fill_way(fill_way), .fill_data(mem_rdata)
  );

  assign wb_in.addr = cpu_addr;
  assign wb_in.data = cpu_wdata;

  sa4c_wbuf #(
    .DEPTH(WB_DEPTH)
  ) i_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wr_accept), .push_entry(wb_in),
    .pop(wb_pop), .head(wb_head),
    .empty(wb_empty), .full(wb_full)
  );

  assign lookup_hit  = cpu_req && (|hit_vec);
  assign rd_miss     = cpu_req && !cpu_we && !lookup_hit;
  assign wr_accept   = cpu_req && cpu_we && !wb_full && (state_q == ST_IDLE);
  assign fill_en     = (state_q == ST_FETCH) && mem_ack;
  assign fill_way    = pick_victim(set_valid, rnd);
  assign wb_pop      = mem_ack && (state_q != ST_FETCH);

  assign cpu_hit     = lookup_hit;
  assign cpu_hit_way = cpu_req ? hit_vec : '0;
  assign cpu_rdata   = hit_data;
  assign cpu_ready   = cpu_we ? wr_accept : lookup_hit;

  // one memory port: fetch while fetching, otherwise drain the buffer head
  assign mem_req   = (state_q == ST_FETCH) || !wb_empty;
  assign mem_we    = (state_q != ST_FETCH);
  assign mem_addr  = (state_q == ST_FETCH) ? cpu_addr : wb_head.addr;
  assign mem_wdata = wb_head.data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rd_miss)  state_d = ST_DRAIN;
      ST_DRAIN: if (wb_empty) state_d = ST_FETCH;
      ST_FETCH: if (mem_ack)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  a_r4_drain_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wb_empty);
  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata))));
  a_r5_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&set_valid)) |-> ((fill_way & set_valid) == '0));
  a_r5_single_fill_way: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> $onehot(fill_way));
  a_r8_no_write_allocate: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |-> !fill_en);
  a_r4_fetch_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (cpu_req && !cpu_we) |-> lookup_hit);
endmodule

// File: tb/test_sa4_wt_cache.sv
module test_sa4_wt_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic [3:0]  cpu_hit_way;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  sa4_wt_cache i_sa4_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_hit_way(cpu_hit_way),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  int vectors = 0, miscompares = 0, cyc = 0;
  int lat = 2;
  bit done = 0;

  // behavioural reference state
  bit          m_val [256][4];
  logic [21:0] m_tag [256][4];
  logic [31:0] gold   [logic [29:0]];
  logic [31:0] mstore [logic [29:0]];
  logic [63:0] wq [$];
  bit          pending_fill = 0;
  bit          prev_open = 0, prev_we = 0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  int          stall_seen = 0;

  function automatic logic [31:0] init_word(logic [29:0] w);
    return ({2'b00, w} * 32'h9E37_79B1) ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] gold_rd(logic [29:0] w);
    return gold.exists(w) ? gold[w] : init_word(w);
  endfunction
  function automatic logic [31:0] mem_rd(logic [29:0] w);
    return mstore.exists(w) ? mstore[w] : init_word(w);
  endfunction
  function automatic int set_of(logic [31:0] a);
    return int'((a / 4) % 256);
  endfunction
  function automatic int find_way(logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_val[set_of(a)][w] && m_tag[set_of(a)][w] == a[31:10]) return w;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // memory responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req && rst_n) begin
        cnt++;
        if (cnt >= lat) begin
          mem_ack = 1'b1;
          if (mem_we) mstore[mem_addr[31:2]] = mem_wdata;
          else        mem_rdata = mem_rd(mem_addr[31:2]);
        end
      end
    end
  end

  // per-cycle comparison against the reference model
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        if (cpu_req) begin
          int mw;
          if (pending_fill) begin
            int fw, lowfree;
            fw = -1;
            lowfree = -1;
            for (int w = 0; w < 4; w++) if (cpu_hit_way[w]) fw = w;
            for (int w = 3; w >= 0; w--) if (!m_val[set_of(cpu_addr)][w]) lowfree = w;
            chk(cpu_hit && $onehot(cpu_hit_way), "R4", "hit after fetch", {31'd0, cpu_hit}, 32'd1);
            if (lowfree >= 0)
              chk(fw == lowfree, "R5", "fill way", fw, lowfree);
            if (fw >= 0) begin
              m_val[set_of(cpu_addr)][fw] = 1'b1;
              m_tag[set_of(cpu_addr)][fw] = cpu_addr[31:10];
            end
            pending_fill = 0;
          end
          mw = find_way(cpu_addr);
          chk(cpu_hit == (mw >= 0), "R1/R8", "hit flag", {31'd0, cpu_hit}, {31'd0, mw >= 0});
          chk($countones(cpu_hit_way) <= 1, "R3", "hit way one-hot", {28'd0, cpu_hit_way}, 32'd1);
          if (mw >= 0)
            chk(cpu_hit_way == (4'b1 << mw), "R2", "hit way", {28'd0, cpu_hit_way}, 32'd1 << mw);
          if (!cpu_we) begin
            chk(cpu_ready == (mw >= 0), "R2/R4", "read ready", {31'd0, cpu_ready}, {31'd0, mw >= 0});
            if (cpu_ready)
              chk(cpu_rdata == gold_rd(cpu_addr[31:2]), "R2/R7", "read data", cpu_rdata, gold_rd(cpu_addr[31:2]));
          end else begin
            chk(cpu_ready == (wq.size() < 4), "R9", "write ready", {31'd0, cpu_ready}, {31'd0, wq.size() < 4});
            if (!cpu_ready) stall_seen++;
            if (cpu_ready) begin
              wq.push_back({cpu_addr[31:2], 2'b00, cpu_wdata});
              gold[cpu_addr[31:2]] = cpu_wdata;
            end
          end
        end
        if (mem_req && !mem_we) begin
          chk(wq.size() == 0, "R4", "fetch with writes pending", wq.size(), 0);
          chk(mem_addr[31:2] == cpu_addr[31:2], "R4", "fetch address", mem_addr, cpu_addr);
        end
        if (prev_open)
          chk(mem_req && mem_we == prev_we && mem_addr == prev_addr && (!mem_we || mem_wdata == prev_wdata),
              "R11", "held request", mem_addr, prev_addr);
        if (mem_ack && mem_req && mem_we) begin
          if (wq.size() == 0) chk(0, "R6", "unexpected memory write", mem_addr, 0);
          else begin
            logic [63:0] e;
            e = wq.pop_front();
            chk(mem_addr[31:2] == e[63:34] && mem_wdata == e[31:0], "R6", "memory write",
                mem_wdata, e[31:0]);
          end
        end
        if (mem_ack && mem_req && !mem_we) pending_fill = 1;
        prev_open  = mem_req && !mem_ack;
        prev_we    = mem_we;
        prev_addr  = mem_addr;
        prev_wdata = mem_wdata;
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        miscompares++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  task automatic op(bit we, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #2;
    while (!cpu_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int tag, int set, int off);
    return (32'(tag) << 10) | (32'(set) << 2) | 32'(off);
  endfunction

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R10: idle after reset
    chk(mem_req == 1'b0, "R10", "mem_req after reset", {31'd0, mem_req}, 0);
    chk(cpu_hit == 1'b0, "R10", "no hit after reset", {31'd0, cpu_hit}, 0);

    // R5 fill order into an empty set, R1 offset ignored
    for (int t = 1; t <= 4; t++) op(0, mk(t, 5, 0), 0);
    op(0, mk(2, 5, 3), 0);
    op(0, mk(4, 5, 1), 0);
    // R5: a fifth tag must evict one of the four
    op(0, mk(9, 5, 0), 0);
    for (int t = 1; t <= 4; t++) op(0, mk(t, 5, 2), 0);
    idle(2);

    // R7: write hit visible immediately, slow memory
    lat = 5;
    op(0, mk(1, 5, 0), 0);
    op(1, mk(1, 5, 0), 32'hCAFE_0001);
    op(0, mk(1, 5, 2), 0);
    // R8 and R4: write miss, then read of same word waits for drain
    op(1, mk(77, 40, 0), 32'hBEEF_0077);
    op(0, mk(77, 40, 1), 0);
    idle(2);

    // R9: burst of writes against slow memory
    lat = 6;
    stall_seen = 0;
    for (int i = 0; i < 7; i++) op(1, mk(100 + i, 60, 0), 32'h1000 + i);
    idle(1);
    chk(stall_seen > 0, "R9", "stall when full", stall_seen, 1);
    op(0, mk(103, 60, 0), 0);
    idle(2);

    // mixed traffic over two crowded sets
    seed = 32'h2468_ACE1;
    for (int i = 0; i < 1500; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      lat  = 1 + int'(seed[27:26]);
      op(seed[31:30] == 2'b11, mk(int'(seed[12:10]) % 6, seed[20] ? 3 : 7, int'(seed[1:0])),
         seed ^ 32'h0F0F_F0F0);
    end
    idle(40);
    chk(wq.size() == 0, "R6", "all writes reached memory", wq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule